// File: doc/BRIEF.md
# RTC Configuration Guard with Key Unlock and Init Handshake

This block stands between a register write bus and the configuration registers of a real-time clock. A key register accepts a two-byte unlock sequence; only while the guard is open do writes to the control, calibration and status registers land. A request bit in the status register puts the clock into init mode. The calendar stops and, after a short settle time, an acknowledge flag lets software load time, date, prescaler and subsecond values. Clearing the request releases the calendar after a fixed restart delay. At that point a synchronised flag tells software that time and date reads can be trusted again.

The bus is a plain one-cycle register port. A write with `wr_en` high is taken on the rising clock edge and never stalled, so no back-pressure exists. Reads are combinational from `rd_addr`. The address map is: 0 key, 1 status, 2 time, 3 date, 4 prescaler, 5 control, 6 calibration, 7 subseconds.

Top module: `rtc_guard`

## Requirements
- R1: A key write (address 0) whose low byte is 0xCA, followed by a key write whose low byte is 0x53, raises `unlocked` on the edge of the second write; bits above the low byte are ignored.
- R2: A key write with low byte 0xFF drops `unlocked` on its edge.
- R3: A key write that breaks the sequence leaves the guard locked: a first byte other than 0xCA, a second byte other than 0x53, or a fresh 0xCA while open (which locks and restarts the sequence).
- R4: Status bit 7 is the init request, writable only while unlocked; status bit 6 (`init_ack`) rises on the second edge after the edge that set the request.
- R5: `init_ack` falls on the same edge that clears the request.
- R6: `cal_run` falls on the edge that sets the request and stays low while the request is set.
- R7: After the request is cleared, `cal_run` rises exactly 4 edges later; status bit 5 (`regs_synced`) falls on the clearing edge and rises with `cal_run`; setting the request again during the countdown cancels the restart.
- R8: Writes to control (5) and calibration (6) take effect only while unlocked; locked writes leave the stored value unchanged.
- R9: Writes to time (2), date (3), prescaler (4) and subseconds (7) take effect only while unlocked and `init_ack` is high.
- R10: Reads return stored contents at any time; key reads return zero; status reads return request, acknowledge and synced at bits 7, 6, 5 with other bits zero. After reset the guard is locked, `cal_run` and `regs_synced` are high, `init_ack` is low and all stored registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data for `rd_addr` |
| unlocked | output | 1 | Protected registers writable |
| cal_run | output | 1 | Calendar counting enabled |
| init_ack | output | 1 | Init mode entered, loads allowed |
| regs_synced | output | 1 | Time and date readable after init exit |

## Verification
The embedded properties assume that reset is asserted for at least one edge and that `wr_addr` and `wr_data` are defined whenever `wr_en` is high. They also assume that only one write is presented per edge, which the single port enforces. The bench drives every input on the falling edge from tasks and holds `wr_en` high for exactly one edge per write. It leaves the address lines at a known value between writes, so no property sees undefined write fields. Each scenario reads results back through `rd_data` and the flag outputs, not through internal state.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
  localparam int ADDR_W = 3;
  localparam int SLOTS  = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_KEY    = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_TIME   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRESC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CALIB  = 3'd6;
  localparam logic [ADDR_W-1:0] A_SUBSEC = 3'd7;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;
  localparam logic [7:0] KEY_CLOSE  = 8'hFF;

  localparam int ST_REQ_BIT  = 7;
  localparam int ST_ACK_BIT  = 6;
  localparam int ST_SYNC_BIT = 5;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_ARMED  = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_PLAIN = 2'd1,
    SLOT_INIT  = 2'd2
  } slot_kind_e;

  function automatic slot_kind_e slot_kind(input int idx);
    case (idx)
      int'(A_CTRL), int'(A_CALIB): return SLOT_PLAIN;
      int'(A_TIME), int'(A_DATE), int'(A_PRESC), int'(A_SUBSEC): return SLOT_INIT;
      default: return SLOT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_key_fsm.sv
module rtc_key_fsm
  import rtc_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       unlocked
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      case (state_q)
        KEY_ARMED: state_d = (key_byte == KEY_SECOND) ? KEY_OPEN : KEY_LOCKED;
        default:   state_d = (key_byte == KEY_FIRST)  ? KEY_ARMED : KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == KEY_OPEN);

  assert_unlock_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && key_byte == KEY_SECOND));
  assert_close_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_byte == KEY_CLOSE) |=> !unlocked);
  assert_bad_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !unlocked && key_byte != KEY_FIRST && key_byte != KEY_SECOND) |=> !unlocked);
endmodule

// File: rtl/rtc_init_seq.sv
module rtc_init_seq #(
  parameter int ACK_DLY     = 2,
  parameter int RESTART_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic req_val,
  output logic init_req,
  output logic init_ack,
  output logic cal_run,
  output logic regs_synced
);
  localparam int ACW = (ACK_DLY > 1) ? $clog2(ACK_DLY) : 1;
  localparam int RCW = $clog2(RESTART_CYC + 1);
  localparam logic [ACW-1:0] ACK_LAST = ACW'(ACK_DLY - 1);
  localparam logic [RCW-1:0] RST_LOAD = RCW'(RESTART_CYC);

  logic [ACW-1:0] ack_cnt_q;
  logic [RCW-1:0] rst_cnt_q;

  wire set_req = req_wr &&  req_val && !init_req;
  wire clr_req = req_wr && !req_val &&  init_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req    <= 1'b0;
      init_ack    <= 1'b0;
      ack_cnt_q   <= '0;
      rst_cnt_q   <= '0;
      cal_run     <= 1'b1;
      regs_synced <= 1'b1;
    end else if (set_req) begin
      init_req  <= 1'b1;
      ack_cnt_q <= '0;
      rst_cnt_q <= '0;
      cal_run   <= 1'b0;
    end else if (clr_req) begin
      init_req    <= 1'b0;
      init_ack    <= 1'b0;
      ack_cnt_q   <= '0;
      rst_cnt_q   <= RST_LOAD;
      regs_synced <= 1'b0;
    end else begin
      if (init_req && !init_ack) begin
        if (ack_cnt_q == ACK_LAST) init_ack <= 1'b1;
        else                       ack_cnt_q <= ack_cnt_q + 1'b1;
      end
      if (rst_cnt_q != '0) begin
        rst_cnt_q <= rst_cnt_q - 1'b1;
        if (rst_cnt_q == RCW'(1)) begin
          cal_run     <= 1'b1;
          regs_synced <= 1'b1;
        end
      end
    end
  end

  assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_ack |-> init_req);
  assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_req) |-> !init_ack);
  assert_halt_in_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> !cal_run);
  assert_sync_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_req) |-> !regs_synced);
  assert_sync_with_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_run) |-> regs_synced);
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              unlocked,
  input  logic              init_ack,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (slot_kind(i) == SLOT_NONE) begin
          slot_q[i] <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(i) && unlocked &&
                     (slot_kind(i) == SLOT_PLAIN || init_ack)) begin
          slot_q[i] <= wr_data;
        end
      end
    end
  end

  assign rd_data = slot_q[rd_addr];

  for (genvar g = 0; g < SLOTS; g++) begin : g_chk
    if (slot_kind(g) != SLOT_NONE) begin : g_hold
      assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(slot_q[g]));
    end
    if (slot_kind(g) == SLOT_INIT) begin : g_init
      assert_init_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !init_ack |=> $stable(slot_q[g]));
    end
  end
endmodule

// File: rtl/rtc_guard.sv
module rtc_guard
  import rtc_guard_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ACK_DLY     = 2,
  parameter int RESTART_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              unlocked,
  output logic              cal_run,
  output logic              init_ack,
  output logic              regs_synced
);
  logic              init_req;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] status_word;

  wire key_wr    = wr_en && (wr_addr == A_KEY);
  wire status_wr = wr_en && (wr_addr == A_STATUS) && unlocked;

  rtc_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (wr_data[7:0]),
    .unlocked (unlocked)
  );

  rtc_init_seq #(
    .ACK_DLY     (ACK_DLY),
    .RESTART_CYC (RESTART_CYC)
  ) u_init (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_wr      (status_wr),
    .req_val     (wr_data[ST_REQ_BIT]),
    .init_req    (init_req),
    .init_ack    (init_ack),
    .cal_run     (cal_run),
    .regs_synced (regs_synced)
  );

  rtc_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .unlocked (unlocked),
    .init_ack (init_ack),
    .rd_addr  (rd_addr),
    .rd_data  (bank_rd)
  );

  always_comb begin
    status_word              = '0;
    status_word[ST_REQ_BIT]  = init_req;
    status_word[ST_ACK_BIT]  = init_ack;
    status_word[ST_SYNC_BIT] = regs_synced;
  end

  always_comb begin
    case (rd_addr)
      A_KEY:    rd_data = '0;
      A_STATUS: rd_data = status_word;
      default:  rd_data = bank_rd;
    endcase
  end

  assert_locked_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STATUS && !unlocked) |=> $stable(init_req));
endmodule

// File: tb/rtc_guard_tb.sv
module rtc_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        unlocked, cal_run, init_ack, regs_synced;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .unlocked(unlocked), .cal_run(cal_run), .init_ack(init_ack),
    .regs_synced(regs_synced)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic open_key();
    wr(3'd0, 32'hCA);
    wr(3'd0, 32'h53);
  endtask

  task automatic t_reset();
    check("R10 unlocked", {31'd0, unlocked}, 32'd0);
    check("R10 cal_run", {31'd0, cal_run}, 32'd1);
    check("R10 init_ack", {31'd0, init_ack}, 32'd0);
    rd_chk("R10 status", 3'd1, 32'h20);
    rd_chk("R10 ctrl", 3'd5, 32'h0);
    rd_chk("R10 time", 3'd2, 32'h0);
  endtask

  task automatic t_locked_writes();
    wr(3'd5, 32'h1234);
    rd_chk("R8 locked ctrl", 3'd5, 32'h0);
    wr(3'd1, 32'h80);
    check("R4 locked req ignored run", {31'd0, cal_run}, 32'd1);
    rd_chk("R4 locked req ignored status", 3'd1, 32'h20);
  endtask

  task automatic t_unlock();
    wr(3'd0, 32'hABCD00CA);
    check("R1 half sequence", {31'd0, unlocked}, 32'd0);
    wr(3'd0, 32'h77000053);
    check("R1 unlocked", {31'd0, unlocked}, 32'd1);
    rd_chk("R10 key reads zero", 3'd0, 32'h0);
    wr(3'd5, 32'h55AA);
    rd_chk("R8 ctrl write", 3'd5, 32'h55AA);
    wr(3'd6, 32'h1FF);
    rd_chk("R8 calib write", 3'd6, 32'h1FF);
    wr(3'd2, 32'h123456);
    rd_chk("R9 time w/o init", 3'd2, 32'h0);
  endtask

  task automatic t_relock();
    wr(3'd0, 32'hFF);
    check("R2 locked", {31'd0, unlocked}, 32'd0);
    wr(3'd5, 32'h1);
    rd_chk("R8 ctrl after lock", 3'd5, 32'h55AA);
  endtask

  task automatic t_broken();
    wr(3'd0, 32'hCA); wr(3'd0, 32'h12);
    check("R3 bad second", {31'd0, unlocked}, 32'd0);
    wr(3'd0, 32'h53);
    check("R3 stale second", {31'd0, unlocked}, 32'd0);
    wr(3'd0, 32'h11); wr(3'd0, 32'h53);
    check("R3 bad first", {31'd0, unlocked}, 32'd0);
    open_key();
    wr(3'd0, 32'hCA);
    check("R3 restart while open", {31'd0, unlocked}, 32'd0);
    wr(3'd0, 32'h53);
    check("R3 restarted sequence", {31'd0, unlocked}, 32'd1);
  endtask

  task automatic t_init();
    wr(3'd1, 32'h80);
    check("R6 run stops", {31'd0, cal_run}, 32'd0);
    check("R4 ack edge0", {31'd0, init_ack}, 32'd0);
    @(negedge clk);
    check("R4 ack edge1", {31'd0, init_ack}, 32'd0);
    @(negedge clk);
    check("R4 ack edge2", {31'd0, init_ack}, 32'd1);
    rd_chk("R10 status init", 3'd1, 32'hE0);
    wr(3'd2, 32'h123456); wr(3'd3, 32'h2101); wr(3'd4, 32'h1F03FF); wr(3'd7, 32'h3);
    rd_chk("R9 time load", 3'd2, 32'h123456);
    rd_chk("R9 date load", 3'd3, 32'h2101);
    rd_chk("R9 presc load", 3'd4, 32'h1F03FF);
    rd_chk("R9 subsec load", 3'd7, 32'h3);
    wr(3'd0, 32'hFF);
    wr(3'd2, 32'h0);
    rd_chk("R9 locked in init", 3'd2, 32'h123456);
    check("R6 still halted", {31'd0, cal_run}, 32'd0);
    open_key();
    wr(3'd1, 32'h0);
    check("R5 ack clears", {31'd0, init_ack}, 32'd0);
    check("R7 sync clears", {31'd0, regs_synced}, 32'd0);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R7 still waiting", {31'd0, cal_run}, 32'd0);
    end
    @(negedge clk);
    check("R7 run resumes", {31'd0, cal_run}, 32'd1);
    check("R7 sync set", {31'd0, regs_synced}, 32'd1);
  endtask

  task automatic t_cancel();
    wr(3'd1, 32'h80);
    repeat (3) @(negedge clk);
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h80);
    repeat (8) @(negedge clk);
    check("R7 cancel keeps halt", {31'd0, cal_run}, 32'd0);
    check("R4 ack again", {31'd0, init_ack}, 32'd1);
    wr(3'd1, 32'h0);
    repeat (4) @(negedge clk);
    check("R7 run after cancel", {31'd0, cal_run}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_writes();
    t_unlock();
    t_relock();
    t_broken();
    t_init();
    t_cancel();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule